// File: doc/BRIEF.md
# Stack Pointer Register Unit

This unit holds the stack pointer of a small 8-bit processor core. The stack lives in data memory and grows toward lower addresses, and the pointer always names the current top-of-stack slot. The core adjusts the pointer with four one-hot strobes. A single-byte push moves it down by one and a single-byte pop moves it up by one. A return-address push, used on a call or an interrupt, moves it down by two, and a return moves it up by two. The unit also drives the data-memory address for the access that goes with the strobe. A push writes at the current pointer and then decrements. A pop increments first and then reads.

Software reads and writes the pointer as two byte-wide I/O registers, a low byte and a high byte, on an 8-bit I/O bus. The number of implemented pointer bits is a build parameter, and a second parameter removes the high byte for parts with a small data space. A warning output stays high while the pointer is at or below 0x60, the region that the stack must not reach in normal use.

Top module: `stkptr_unit`

## Requirements
- R1: After reset the pointer is zero. Both byte registers read 0x00, `stk_addr` is 0, and `low_warn` is 1.
- R2: `op_push1` alone, with no I/O write to the pointer in the same cycle, lowers the pointer by one at the clock edge.
- R3: `op_pop1` alone, with no I/O write to the pointer in the same cycle, raises the pointer by one at the clock edge.
- R4: `op_push2` alone lowers the pointer by two, and `op_pop2` alone raises it by two.
- R5: When `io_wr` is high, a write to address `LO_ADDR` (default 0x2C) replaces bits 7:0 and a write to `HI_ADDR` (default 0x2D) replaces bits 15:8. The other byte is kept. When `io_rd` is high, `io_rdata` returns the addressed byte in the same cycle.
- R6: An I/O write to either pointer byte in the same cycle as a push or pop strobe takes the written value, and the strobe has no effect.
- R7: Pointer arithmetic wraps modulo 2^PTR_W. With the default PTR_W of 12, a push from 0x000 gives 0xFFF and a pop from 0xFFF gives 0x000.
- R8: Pointer bits at or above PTR_W always read as zero and ignore writes. With the defaults, writing 0xFF to the high byte reads back as 0x0F.
- R9: While a push strobe is active, `stk_addr` equals the current pointer. While a pop strobe is active, it equals the pointer plus one, modulo 2^PTR_W. With no strobe active, it equals the pointer.
- R10: `low_warn` is 1 exactly when the pointer is at or below 0x60.
- R11: A cycle with more than one operation strobe high leaves the pointer unchanged, and `stk_addr` equals the pointer.
- R12: With HAS_HI = 0 the pointer is at most 8 bits wide. The high-byte address reads 0x00, writes to it are ignored, and a strobe in the same cycle still applies.
- R13: `io_rdata` is 0x00 when `io_rd` is low or when the address matches neither pointer byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 6 | I/O register address |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, combinational |
| op_push1 | input | 1 | Push one data byte |
| op_pop1 | input | 1 | Pop one data byte |
| op_push2 | input | 1 | Push a two-byte return address |
| op_pop2 | input | 1 | Pop a two-byte return address |
| stk_addr | output | 16 | Data-memory address for the current stack access |
| low_warn | output | 1 | Pointer is at or below 0x60 |

## Verification
`stk_addr`, `io_rdata` and `low_warn` are combinational, so each is due in the same cycle as the strobe or pointer value that causes it. A change to the pointer appears one clock edge after the cycle that requests it. The driver applies each stimulus on a falling edge and queues the combinational results expected for that cycle. The monitor compares them shortly after the same falling edge, well before the next rising edge. The effect of a pointer update is checked by a read in a later cycle, so every comparison lands in the cycle where its value is defined.

// File: rtl/stkptr_pkg.sv
package stkptr_pkg;

  typedef enum logic [2:0] {
    SP_IDLE  = 3'd0,
    SP_PUSH1 = 3'd1,
    SP_POP1  = 3'd2,
    SP_PUSH2 = 3'd3,
    SP_POP2  = 3'd4
  } sp_op_e;

  // Next pointer value for an operation, wrapped to the implemented width
  function automatic logic [15:0] sp_step(input logic [15:0] sp,
                                          input sp_op_e op,
                                          input logic [15:0] mask);
    logic [15:0] nxt;
    case (op)
      SP_PUSH1: nxt = sp - 16'd1;
      SP_POP1:  nxt = sp + 16'd1;
      SP_PUSH2: nxt = sp - 16'd2;
      SP_POP2:  nxt = sp + 16'd2;
      default:  nxt = sp;
    endcase
    return nxt & mask;
  endfunction

  // Memory address touched this cycle: post-decrement push, pre-increment pop
  function automatic logic [15:0] sp_access(input logic [15:0] sp,
                                            input sp_op_e op,
                                            input logic [15:0] mask);
    logic [15:0] a;
    case (op)
      SP_POP1, SP_POP2: a = (sp + 16'd1) & mask;
      default:          a = sp;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/stkptr_opdec.sv
module stkptr_opdec
  import stkptr_pkg::*;
(
  input  logic   push1,
  input  logic   pop1,
  input  logic   push2,
  input  logic   pop2,
  output sp_op_e op,
  output logic   multi
);

  logic [3:0] strobes;
  assign strobes = {pop2, push2, pop1, push1};
  assign multi   = ($countones(strobes) > 1);

  always_comb begin
    case (strobes)
      4'b0001: op = SP_PUSH1;
      4'b0010: op = SP_POP1;
      4'b0100: op = SP_PUSH2;
      4'b1000: op = SP_POP2;
      default: op = SP_IDLE;
    endcase
  end

endmodule

// File: rtl/stkptr_ioport.sv
module stkptr_ioport #(
  parameter int          ADDR_W  = 6,
  parameter logic [5:0]  LO_ADDR = 6'h2C,
  parameter logic [5:0]  HI_ADDR = 6'h2D,
  parameter bit          HAS_HI  = 1'b1
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [15:0]       ptr,
  output logic              wr_lo,
  output logic              wr_hi,
  output logic [7:0]        rdata
);

  logic lo_sel;
  logic hi_sel;

  assign lo_sel = (io_addr == LO_ADDR[ADDR_W-1:0]);

  generate
    if (HAS_HI) begin : g_hi
      assign hi_sel = (io_addr == HI_ADDR[ADDR_W-1:0]);
    end else begin : g_no_hi
      assign hi_sel = 1'b0;
    end
  endgenerate

  assign wr_lo = io_wr & lo_sel;
  assign wr_hi = io_wr & hi_sel;

  always_comb begin
    rdata = 8'h00;
    if (io_rd && lo_sel)      rdata = ptr[7:0];
    else if (io_rd && hi_sel) rdata = ptr[15:8];
  end

endmodule

// File: rtl/stkptr_core.sv
module stkptr_core
  import stkptr_pkg::*;
#(
  parameter logic [15:0] PTR_MASK = 16'h0FFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [7:0]  wdata,
  input  sp_op_e      op,
  output logic [15:0] ptr_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= 16'h0000;
    end else if (wr_lo) begin
      ptr_q <= {ptr_q[15:8], wdata} & PTR_MASK;
    end else if (wr_hi) begin
      ptr_q <= {wdata, ptr_q[7:0]} & PTR_MASK;
    end else if (op != SP_IDLE) begin
      ptr_q <= sp_step(ptr_q, op, PTR_MASK);
    end
  end

endmodule

// File: rtl/stkptr_unit.sv
module stkptr_unit
  import stkptr_pkg::*;
#(
  parameter int          PTR_W     = 12,
  parameter bit          HAS_HI    = 1'b1,
  parameter logic [5:0]  LO_ADDR   = 6'h2C,
  parameter logic [5:0]  HI_ADDR   = 6'h2D,
  parameter logic [15:0] LOW_LIMIT = 16'h0060
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  io_addr,
  input  logic        io_rd,
  input  logic        io_wr,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  input  logic        op_push1,
  input  logic        op_pop1,
  input  logic        op_push2,
  input  logic        op_pop2,
  output logic [15:0] stk_addr,
  output logic        low_warn
);

  localparam int IMPL_W = HAS_HI ? PTR_W : ((PTR_W > 8) ? 8 : PTR_W);
  localparam logic [15:0] PTR_MASK = 16'((32'd1 << IMPL_W) - 32'd1);

  sp_op_e      op;
  logic        multi_op;
  logic        wr_lo;
  logic        wr_hi;
  logic        io_wr_hit;
  logic        step_en;
  logic [15:0] ptr_q;

  stkptr_opdec u_opdec (
    .push1 (op_push1),
    .pop1  (op_pop1),
    .push2 (op_push2),
    .pop2  (op_pop2),
    .op    (op),
    .multi (multi_op)
  );

  stkptr_ioport #(
    .ADDR_W  (6),
    .LO_ADDR (LO_ADDR),
    .HI_ADDR (HI_ADDR),
    .HAS_HI  (HAS_HI)
  ) u_io (
    .io_addr (io_addr),
    .io_rd   (io_rd),
    .io_wr   (io_wr),
    .ptr     (ptr_q),
    .wr_lo   (wr_lo),
    .wr_hi   (wr_hi),
    .rdata   (io_rdata)
  );

  stkptr_core #(
    .PTR_MASK (PTR_MASK)
  ) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_lo (wr_lo),
    .wr_hi (wr_hi),
    .wdata (io_wdata),
    .op    (op),
    .ptr_q (ptr_q)
  );

  // Named events for the checker
  assign io_wr_hit = wr_lo | wr_hi;
  assign step_en   = (op != SP_IDLE) & ~io_wr_hit;

  assign stk_addr = sp_access(ptr_q, op, PTR_MASK);
  assign low_warn = (ptr_q <= LOW_LIMIT);

endmodule

// File: rtl/stkptr_chk.sv
module stkptr_chk
  import stkptr_pkg::*;
#(
  parameter logic [15:0] MASK = 16'h0FFF
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] ptr_q,
  input sp_op_e      op,
  input logic        multi_op,
  input logic        io_wr_hit,
  input logic        step_en,
  input logic        wr_lo,
  input logic [7:0]  io_wdata,
  input logic [15:0] stk_addr
);

  // R2
  push1_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && op == SP_PUSH1) |=> ptr_q == (($past(ptr_q) - 16'd1) & MASK));

  // R3
  pop1_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && op == SP_POP1) |=> ptr_q == (($past(ptr_q) + 16'd1) & MASK));

  // R4
  push2_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && op == SP_PUSH2) |=> ptr_q == (($past(ptr_q) - 16'd2) & MASK));

  // R4
  pop2_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && op == SP_POP2) |=> ptr_q == (($past(ptr_q) + 16'd2) & MASK));

  // R6
  wr_lo_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> ptr_q[7:0] == ($past(io_wdata) & MASK[7:0]));

  // R11
  multi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (multi_op && !io_wr_hit) |=> $stable(ptr_q));

  // R8
  impl_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q & ~MASK) == 16'h0000);

  // R9
  push_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == SP_PUSH1 || op == SP_PUSH2) |-> stk_addr == ptr_q);

endmodule

bind stkptr_unit stkptr_chk #(.MASK(PTR_MASK)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ptr_q     (ptr_q),
  .op        (op),
  .multi_op  (multi_op),
  .io_wr_hit (io_wr_hit),
  .step_en   (step_en),
  .wr_lo     (wr_lo),
  .io_wdata  (io_wdata),
  .stk_addr  (stk_addr)
);

// File: tb/stkptr_unit_tb_top.sv
`timescale 1ns/1ps
module stkptr_unit_tb_top;

  localparam logic [5:0] A_LO = 6'h2C;
  localparam logic [5:0] A_HI = 6'h2D;
  localparam int M_BIG = 4096;   // 2^12, default width
  localparam int M_SML = 256;    // 8-bit variant

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  io_addr = '0;
  logic        io_rd = 1'b0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic        op_push1 = 1'b0, op_pop1 = 1'b0, op_push2 = 1'b0, op_pop2 = 1'b0;
  logic [7:0]  rdata_b, rdata_s;
  logic [15:0] addr_b, addr_s;
  logic        warn_b, warn_s;

  always #2 clk = ~clk;

  stkptr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(rdata_b), .op_push1(op_push1), .op_pop1(op_pop1),
    .op_push2(op_push2), .op_pop2(op_pop2), .stk_addr(addr_b), .low_warn(warn_b)
  );

  stkptr_unit #(.PTR_W(8), .HAS_HI(1'b0)) dut_small_i (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(rdata_s), .op_push1(op_push1), .op_pop1(op_pop1),
    .op_push2(op_push2), .op_pop2(op_pop2), .stk_addr(addr_s), .low_warn(warn_s)
  );

  typedef struct {
    int          req;
    int          sel;
    logic [15:0] exp;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int mb = 0;  // model of default instance
  int ms = 0;  // model of small instance

  // Monitor: compares queued expectations shortly after each falling edge
  always begin
    @(negedge clk);
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [15:0] got;
      it = q.pop_front();
      case (it.sel)
        0: got = addr_b;
        1: got = {8'h00, rdata_b};
        2: got = {15'd0, warn_b};
        3: got = addr_s;
        4: got = {8'h00, rdata_s};
        default: got = {15'd0, warn_s};
      endcase
      checks++;
      if (got !== it.exp) begin
        errors++;
        $display("FAIL R%0d sel=%0d: actual %h expected %h", it.req, it.sel, got, it.exp);
      end
    end
  end

  function automatic int stepped(int m, logic [3:0] ops, int modv);
    int d;
    case (ops)
      4'b0001: d = -1;
      4'b0010: d = 1;
      4'b0100: d = -2;
      4'b1000: d = 2;
      default: d = 0;
    endcase
    return (m + d + modv) % modv;
  endfunction

  function automatic int accessed(int m, logic [3:0] ops, int modv);
    if (ops == 4'b0010 || ops == 4'b1000) return (m + 1) % modv;
    return m;
  endfunction

  // Driver: apply one cycle of stimulus, queue the expected combinational results
  // ops = {pop2, push2, pop1, push1}
  task automatic drive(input int req, input bit rd, input bit wr,
                       input logic [5:0] a, input logic [7:0] d, input logic [3:0] ops);
    int rb, rs;
    @(negedge clk);
    io_rd = rd; io_wr = wr; io_addr = a; io_wdata = d;
    {op_pop2, op_push2, op_pop1, op_push1} = ops;
    rb = 0; rs = 0;
    if (rd && a == A_LO) begin rb = mb % 256; rs = ms; end
    else if (rd && a == A_HI) rb = mb / 256;
    // R9 address, R10 warning, then read data
    q.push_back('{9, 0, 16'(accessed(mb, ops, M_BIG))});
    q.push_back('{10, 2, 16'(mb <= 96)});
    q.push_back('{req, 1, 16'(rb)});
    q.push_back('{12, 3, 16'(accessed(ms, ops, M_SML))});
    q.push_back('{12, 5, 16'(ms <= 96)});
    q.push_back('{12, 4, 16'(rs)});
    if (wr && a == A_LO)      mb = (mb / 256) * 256 + d;
    else if (wr && a == A_HI) mb = ((d * 256) + (mb % 256)) % M_BIG;
    else                      mb = stepped(mb, ops, M_BIG);
    if (wr && a == A_LO) ms = d;
    else                 ms = stepped(ms, ops, M_SML);
  endtask

  task automatic rd_both(input int req);
    drive(req, 1'b1, 1'b0, A_LO, 8'h00, 4'b0000);
    drive(req, 1'b1, 1'b0, A_HI, 8'h00, 4'b0000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_both(1);
    // R5 byte writes
    drive(5, 1'b0, 1'b1, A_LO, 8'h00, 4'b0000);
    drive(5, 1'b0, 1'b1, A_HI, 8'h01, 4'b0000);
    rd_both(5);
    // R2 / R3 single-byte push and pop
    drive(2, 1'b0, 1'b0, A_LO, 8'h00, 4'b0001);
    rd_both(2);
    drive(3, 1'b0, 1'b0, A_LO, 8'h00, 4'b0010);
    rd_both(3);
    // R4 return-address push and pop
    drive(4, 1'b0, 1'b0, A_LO, 8'h00, 4'b0100);
    rd_both(4);
    drive(4, 1'b0, 1'b0, A_LO, 8'h00, 4'b1000);
    rd_both(4);
    // R8 unimplemented high bits
    drive(8, 1'b0, 1'b1, A_HI, 8'hFF, 4'b0000);
    rd_both(8);
    // R7 wrap both ways
    drive(7, 1'b0, 1'b1, A_LO, 8'hFF, 4'b0000);
    drive(7, 1'b0, 1'b0, A_LO, 8'h00, 4'b0010);
    rd_both(7);
    drive(7, 1'b0, 1'b0, A_LO, 8'h00, 4'b0001);
    rd_both(7);
    drive(7, 1'b0, 1'b0, A_LO, 8'h00, 4'b0100);
    rd_both(7);
    // R6 write wins over strobe
    drive(6, 1'b0, 1'b1, A_LO, 8'h40, 4'b0001);
    rd_both(6);
    drive(6, 1'b0, 1'b1, A_HI, 8'h02, 4'b1000);
    rd_both(6);
    // R11 conflicting strobes
    drive(11, 1'b0, 1'b0, A_LO, 8'h00, 4'b0011);
    rd_both(11);
    drive(11, 1'b0, 1'b0, A_LO, 8'h00, 4'b1100);
    rd_both(11);
    // R10 warning threshold
    drive(10, 1'b0, 1'b1, A_HI, 8'h00, 4'b0000);
    drive(10, 1'b0, 1'b1, A_LO, 8'h61, 4'b0000);
    rd_both(10);
    drive(10, 1'b0, 1'b0, A_LO, 8'h00, 4'b0001);
    rd_both(10);
    drive(10, 1'b0, 1'b0, A_LO, 8'h00, 4'b0010);
    rd_both(10);
    // R13 no read strobe, and an unmatched address
    drive(13, 1'b0, 1'b0, A_LO, 8'h00, 4'b0000);
    drive(13, 1'b1, 1'b0, 6'h05, 8'h00, 4'b0000);
    // R12 absent high byte: write ignored, strobe still applies
    drive(12, 1'b0, 1'b1, A_HI, 8'h33, 4'b0001);
    rd_both(12);
    drive(1, 1'b0, 1'b0, A_LO, 8'h00, 4'b0000);
    @(negedge clk);
    #2;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule